// File: doc/BRIEF.md
# UART FIFO Ready and Receive Trigger Logic

This block drives the two active-low DMA-style handshake pins of a 16550-style serial port with 16-entry FIFOs. It also produces the receive-data-available condition that the interrupt logic consumes. The block does not hold the FIFOs or the character-timeout counter. It watches their occupancy counts and the strobes that load the transmit side or unload the receive side. From the occupancy that will hold after this cycle's strobe, it decides at each clock edge whether each pin is asserted.

Two ready modes exist. In the single-character mode, each pin simply follows the presence or absence of data: the receive pin asserts whenever a character is held, and the transmit pin asserts whenever nothing is queued. In the block-transfer mode, which applies only with the FIFOs enabled and the mode bit set, both pins have hysteresis. The receive pin asserts at the programmed trigger level or on a timeout, and it stays asserted until the FIFO is empty. The transmit pin asserts on empty and stays asserted until the FIFO is full.

Each pin is the output of a two-state machine. The receive machine has the states RX_IDLE (pin high) and RX_READY (pin low). Its transitions are *rx_arm* (RX_IDLE to RX_READY) and *rx_drain* (RX_READY to RX_IDLE). The transmit machine has the states TX_READY (pin low) and TX_WAIT (pin high). Its transitions are *tx_load* (TX_READY to TX_WAIT) and *tx_empty* (TX_WAIT to TX_READY).

Top module: `uart_fifo_rdy`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, rx_rdy_n is 1 and tx_rdy_n is 0.
- R2: With fifo_en=1, rx_avail is 1 exactly when rx_count is at least the trigger level or char_timeout is 1. The trigger level is set by trig_sel: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14.
- R3: With fifo_en=0, trig_sel has no effect and the threshold is one character: rx_avail is 1 exactly when rx_count is at least 1 or char_timeout is 1.
- R4: In mode 0 (fifo_en=0, or mode_sel=0), rx_rdy_n after a clock edge is 0 exactly when the next receive occupancy at that edge is non-zero.
- R5: In mode 1 (fifo_en=1 and mode_sel=1), rx_rdy_n goes to 0 at an edge where the next receive occupancy is non-zero and either reaches the trigger level or char_timeout is 1. Below the level and with no timeout, it stays at 1.
- R6: In mode 1, once rx_rdy_n is 0 it stays 0 while the next occupancy is non-zero, even below the trigger level. It returns to 1 at the edge where the next occupancy is 0.
- R7: In mode 0, tx_rdy_n after a clock edge is 0 exactly when the next transmit occupancy is 0.
- R8: In mode 1, tx_rdy_n goes to 0 when the next transmit occupancy is 0 and stays 0 until the next occupancy equals 16. It then stays 1 until the occupancy returns to 0.
- R9: The next receive occupancy is rx_count minus 1 when rx_pop=1 and rx_count>0, and rx_count otherwise. The next transmit occupancy is tx_count plus 1 when tx_push=1 and tx_count is below its capacity (16 with fifo_en=1, 1 with fifo_en=0), and tx_count otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled (0: one-character holding registers) |
| mode_sel | input | 1 | Ready-pin mode bit (1 selects block-transfer mode when fifo_en=1) |
| trig_sel | input | 2 | Receive trigger level select |
| char_timeout | input | 1 | Character timeout indication from the external counter |
| rx_count | input | 5 | Receive FIFO occupancy, 0 to 16 |
| tx_count | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| rx_pop | input | 1 | A receive character is read this cycle |
| tx_push | input | 1 | A transmit character is loaded this cycle |
| rx_rdy_n | output | 1 | Active-low receive ready pin (registered) |
| tx_rdy_n | output | 1 | Active-low transmit ready pin (registered) |
| rx_avail | output | 1 | Receive-data-available condition for the interrupt logic |

## Verification
Directed ramps fill the transmit FIFO one character at a time to 16 and then drain it in mode 1. This separates true hysteresis from plain level following, since the pin must stay low through occupancies 1 to 15 on the way up and stay high through them on the way down. A receive ramp with trigger level 4 tells a threshold-armed pin from an any-data pin, and the drain that follows tells hold-until-empty from release-below-level. Single-character pops and pushes check that the pins follow the occupancy after the strobe and not the count before it. Thousands of random cycles then mix modes, trigger codes, timeouts and counts, including mode changes while a pin is held, and compare every pin and rx_avail with a bench model.

// File: rtl/uart_rdy_pkg.sv
package uart_rdy_pkg;

    // Receive pin states: RX_IDLE drives the pin high, RX_READY drives it low.
    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_READY = 1'b1
    } rx_state_e;

    // Transmit pin states: TX_READY drives the pin low, TX_WAIT drives it high.
    typedef enum logic {
        TX_READY = 1'b0,
        TX_WAIT  = 1'b1
    } tx_state_e;

    // Trigger-select encodings.
    localparam logic [1:0] TRIG_ONE     = 2'b00;
    localparam logic [1:0] TRIG_QUARTER = 2'b01;
    localparam logic [1:0] TRIG_HALF    = 2'b10;
    localparam logic [1:0] TRIG_NEAR    = 2'b11;

endpackage

// File: rtl/uart_rdy_thresh.sv
module uart_rdy_thresh
    import uart_rdy_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          fifo_en,
    input  logic          mode_sel,
    input  logic [1:0]    trig_sel,
    input  logic          char_timeout,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic          rx_pop,
    input  logic          tx_push,
    output logic [CW-1:0] rx_next,
    output logic [CW-1:0] tx_next,
    output logic [CW-1:0] rx_level,
    output logic          mode1,
    output logic          rx_avail
);

    localparam logic [CW-1:0] LVL_ONE     = CW'(1);
    localparam logic [CW-1:0] LVL_QUARTER = CW'(DEPTH / 4);
    localparam logic [CW-1:0] LVL_HALF    = CW'(DEPTH / 2);
    localparam logic [CW-1:0] LVL_NEAR    = CW'(DEPTH - 2);
    localparam logic [CW-1:0] CAP_FIFO    = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_HOLD    = CW'(1);

    logic [CW-1:0] tx_cap;

    assign mode1  = fifo_en & mode_sel;
    assign tx_cap = fifo_en ? CAP_FIFO : CAP_HOLD;

    // Trigger decode; holding-register operation forces one character.
    always_comb begin
        if (!fifo_en) begin
            rx_level = LVL_ONE;
        end else begin
            unique case (trig_sel)
                TRIG_ONE:     rx_level = LVL_ONE;
                TRIG_QUARTER: rx_level = LVL_QUARTER;
                TRIG_HALF:    rx_level = LVL_HALF;
                TRIG_NEAR:    rx_level = LVL_NEAR;
                default:      rx_level = LVL_ONE;
            endcase
        end
    end

    // Occupancy after this cycle's strobes.
    always_comb begin
        rx_next = rx_count;
        if (rx_pop && (rx_count != '0)) rx_next = rx_count - CW'(1);
        tx_next = tx_count;
        if (tx_push && (tx_count < tx_cap)) tx_next = tx_count + CW'(1);
    end

    assign rx_avail = (rx_count >= rx_level) | char_timeout;

endmodule

// File: rtl/uart_rdy_rx_fsm.sv
module uart_rdy_rx_fsm
    import uart_rdy_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode1,
    input  logic          char_timeout,
    input  logic [CW-1:0] rx_next,
    input  logic [CW-1:0] rx_level,
    output logic          rx_rdy_n
);

    rx_state_e state_q, state_d;
    logic      held, armed;

    assign held  = (rx_next != '0);
    assign armed = held & (~mode1 | (rx_next >= rx_level) | char_timeout);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (armed) state_d = RX_READY;  // rx_arm
            RX_READY: if (!held) state_d = RX_IDLE;   // rx_drain
            default:  state_d = RX_IDLE;
        endcase
    end

    always_comb begin
        rx_rdy_n = (state_q != RX_READY);
    end

endmodule

// File: rtl/uart_rdy_tx_fsm.sv
module uart_rdy_tx_fsm
    import uart_rdy_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode1,
    input  logic [CW-1:0] tx_next,
    output logic          tx_rdy_n
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    tx_state_e state_q, state_d;
    logic      empty, loaded;

    assign empty  = (tx_next == '0);
    assign loaded = ~empty & (~mode1 | (tx_next == FULL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_READY: if (loaded) state_d = TX_WAIT;   // tx_load
            TX_WAIT:  if (empty)  state_d = TX_READY;  // tx_empty
            default:  state_d = TX_READY;
        endcase
    end

    always_comb begin
        tx_rdy_n = (state_q == TX_WAIT);
    end

endmodule

// File: rtl/uart_fifo_rdy.sv
module uart_fifo_rdy
    import uart_rdy_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          mode_sel,
    input  logic [1:0]    trig_sel,
    input  logic          char_timeout,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic          rx_pop,
    input  logic          tx_push,
    output logic          rx_rdy_n,
    output logic          tx_rdy_n,
    output logic          rx_avail
);

    logic [CW-1:0] rx_next, tx_next, rx_level;
    logic          mode1;

    uart_rdy_thresh #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_thresh (
        .fifo_en      (fifo_en),
        .mode_sel     (mode_sel),
        .trig_sel     (trig_sel),
        .char_timeout (char_timeout),
        .rx_count     (rx_count),
        .tx_count     (tx_count),
        .rx_pop       (rx_pop),
        .tx_push      (tx_push),
        .rx_next      (rx_next),
        .tx_next      (tx_next),
        .rx_level     (rx_level),
        .mode1        (mode1),
        .rx_avail     (rx_avail)
    );

    uart_rdy_rx_fsm #(.CW(CW)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode1        (mode1),
        .char_timeout (char_timeout),
        .rx_next      (rx_next),
        .rx_level     (rx_level),
        .rx_rdy_n     (rx_rdy_n)
    );

    uart_rdy_tx_fsm #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode1        (mode1),
        .tx_next      (tx_next),
        .tx_rdy_n     (tx_rdy_n)
    );

endmodule

// File: rtl/uart_fifo_rdy_chk.sv
module uart_fifo_rdy_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          mode_sel,
    input logic          char_timeout,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic          rx_pop,
    input logic          tx_push,
    input logic          rx_rdy_n,
    input logic          tx_rdy_n,
    input logic          rx_avail
);

    localparam logic [CW-1:0] NEAR_LVL = CW'(DEPTH - 2);
    localparam logic [CW-1:0] HOLD_MAX = CW'(DEPTH - 1);

    // R1: reset leaves receive pin released and transmit pin asserted
    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_pins_r1: assert (rx_rdy_n && !tx_rdy_n);
        end
    end

    // R2: a timeout alone raises the available condition
    p_timeout_avail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        char_timeout |-> rx_avail);

    // R4: mode 0 with data left after the edge asserts the receive pin
    p_rx_mode0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(fifo_en && mode_sel) && rx_count != '0 && !rx_pop) |=> !rx_rdy_n);

    // R5: mode 1 at the highest trigger level asserts the receive pin
    p_rx_trig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && mode_sel && rx_count >= NEAR_LVL && !rx_pop) |=> !rx_rdy_n);

    // R6: an empty receive FIFO releases the pin
    p_rx_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |=> rx_rdy_n);

    // R7: an empty transmit side with no load asserts the pin
    p_tx_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0 && !tx_push) |=> !tx_rdy_n);

    // R8: in mode 1 the asserted transmit pin holds below full
    p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && mode_sel && !tx_rdy_n && tx_count != '0 && tx_count < HOLD_MAX)
        |=> !tx_rdy_n);

endmodule

bind uart_fifo_rdy uart_fifo_rdy_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_en      (fifo_en),
    .mode_sel     (mode_sel),
    .char_timeout (char_timeout),
    .rx_count     (rx_count),
    .tx_count     (tx_count),
    .rx_pop       (rx_pop),
    .tx_push      (tx_push),
    .rx_rdy_n     (rx_rdy_n),
    .tx_rdy_n     (tx_rdy_n),
    .rx_avail     (rx_avail)
);

// File: tb/uart_fifo_rdy_test.sv
`timescale 1ns/1ps
module uart_fifo_rdy_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0, mode_sel = 1'b0, char_timeout = 1'b0;
    logic [1:0] trig_sel = 2'b00;
    logic [4:0] rx_count = '0, tx_count = '0;
    logic       rx_pop = 1'b0, tx_push = 1'b0;
    logic       rx_rdy_n, tx_rdy_n, rx_avail;

    int checks = 0;
    int errors = 0;

    bit    exp_rx_low = 1'b0;
    bit    exp_tx_low = 1'b1;
    string rx_tag = "R1";
    string tx_tag = "R1";

    always #2 clk = ~clk;

    uart_fifo_rdy uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .mode_sel(mode_sel),
        .trig_sel(trig_sel), .char_timeout(char_timeout),
        .rx_count(rx_count), .tx_count(tx_count),
        .rx_pop(rx_pop), .tx_push(tx_push),
        .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n), .rx_avail(rx_avail)
    );

    function automatic int level_of(bit en, logic [1:0] tg);
        if (!en) return 1;
        case (tg)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Checks the pins from the previous step, applies new inputs, checks
    // rx_avail, then advances the bench model across the coming edge.
    task automatic step(input int rc, input int tc, input bit push, input bit pop,
                        input bit en, input bit md, input logic [1:0] tg,
                        input bit tmo, input string tag);
        int  rn, tn, cap;
        bit  m1;
        @(negedge clk);
        check(rx_rdy_n, !exp_rx_low, rx_tag);
        check(tx_rdy_n, !exp_tx_low, tx_tag);
        rx_count = 5'(rc); tx_count = 5'(tc); tx_push = push; rx_pop = pop;
        fifo_en = en; mode_sel = md; trig_sel = tg; char_timeout = tmo;
        #1;
        check(rx_avail, (rc >= level_of(en, tg)) || tmo, en ? "R2" : "R3");
        m1  = en && md;
        cap = en ? 16 : 1;
        rn  = (pop && rc > 0) ? rc - 1 : rc;
        tn  = (push && tc < cap) ? tc + 1 : tc;
        if (rn == 0)                                exp_rx_low = 1'b0;
        else if (!m1)                               exp_rx_low = 1'b1;
        else if (rn >= level_of(en, tg) || tmo)     exp_rx_low = 1'b1;
        if (tn == 0)                                exp_tx_low = 1'b1;
        else if (!m1)                               exp_tx_low = 1'b0;
        else if (tn == 16)                          exp_tx_low = 1'b0;
        rx_tag = (tag != "") ? tag : (m1 ? "R5/R6" : "R4");
        tx_tag = (tag != "") ? tag : (m1 ? "R8" : "R7");
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1729));
        repeat (3) @(negedge clk);
        // R1: pins during reset
        check(rx_rdy_n, 1'b1, "R1");
        check(tx_rdy_n, 1'b0, "R1");
        rst_n = 1'b1;

        // R1: first cycle after reset, idle inputs
        step(0, 0, 0, 0, 1, 0, 2'b00, 0, "R1");

        // R9: pop of the only character releases the receive pin at this edge
        step(1, 0, 0, 0, 0, 0, 2'b00, 0, "");
        step(1, 0, 0, 1, 0, 0, 2'b00, 0, "R9");
        // R9: a push into an empty holding register releases the transmit pin
        step(0, 0, 1, 0, 0, 0, 2'b00, 0, "R9");
        step(1, 1, 0, 0, 0, 0, 2'b11, 0, "");
        // R3: trigger field ignored with FIFOs disabled
        step(1, 0, 0, 0, 0, 1, 2'b11, 0, "R3");

        // R8: fill the transmit FIFO in mode 1, then drain it
        step(0, 0, 0, 0, 1, 1, 2'b00, 0, "");
        for (int i = 0; i < 16; i++) step(0, i, 1, 0, 1, 1, 2'b00, 0, "R8");
        step(0, 16, 1, 0, 1, 1, 2'b00, 0, "R8");
        for (int i = 16; i > 0; i--) step(0, i - 1, 0, 0, 1, 1, 2'b00, 0, "R8");

        // R5 and R6: trigger level 4, ramp up then drain
        for (int i = 0; i <= 4; i++) step(i, 0, 0, 0, 1, 1, 2'b01, 0, "R5");
        for (int i = 4; i > 0; i--) step(i, 0, 0, 1, 1, 1, 2'b01, 0, "R6");
        step(0, 0, 0, 0, 1, 1, 2'b01, 0, "R6");

        // R5: timeout below the level arms the receive pin
        step(2, 0, 0, 0, 1, 1, 2'b11, 1, "R5");
        step(2, 0, 0, 0, 1, 1, 2'b11, 0, "R6");
        // R2: each trigger code at and below its level
        step(7, 0, 0, 0, 1, 1, 2'b10, 0, "R2");
        step(8, 0, 0, 0, 1, 1, 2'b10, 0, "R2");
        step(13, 0, 0, 0, 1, 1, 2'b11, 0, "R2");
        step(14, 0, 0, 0, 1, 1, 2'b11, 0, "R2");
        step(3, 0, 0, 0, 1, 0, 2'b01, 0, "R2");

        // Random mix of modes, levels, counts and strobes
        for (int n = 0; n < 3000; n++) begin
            bit en = ($urandom % 4) != 0;
            int lim = en ? 17 : 2;
            step($urandom % lim, $urandom % lim, $urandom % 2, $urandom % 2,
                 en, $urandom % 2, 2'($urandom % 4), ($urandom % 8) == 0, "");
        end
        step(0, 0, 0, 0, 1, 0, 2'b00, 0, "");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule